// File: doc/BRIEF.md
# Et lookup and output source selector

One channel of a calorimeter trigger output stage. Each crossing clock the block takes a filtered 10-bit sample and converts it through a 1024-entry by 8-bit lookup memory into a transverse-energy count, where one count is 0.25 GeV and the zero-energy pedestal is 8. A host loads the memory with a straight line that maps the sample pedestal of 50 onto the output pedestal of 8. The slope of that line completes the energy-to-Et scaling for the channel.

The block sends one 8-bit word on every crossing clock of a 159-clock turn. A four-way selector chooses that word from one of four sources: the lookup result, a programmable fixed register, a one-turn circular buffer, or a pseudo-random generator. Two source codes in a control register decide the choice, one for clocks flagged as live crossings and one for all other clocks. In physics running the lookup result goes out on live crossings and the fixed value 8 goes out elsewhere. A noisy channel is silenced by choosing the fixed register for both classes.

The circular buffer is 159 entries deep and its address restarts on the turn marker. In record mode it stores every transmitted word, so a full turn of what left the channel can be read back by playback. In playback mode its contents are frozen and replay host-loaded simulation data. A simple register write port loads the memory, the fixed value, the control bits, the noise seed and the buffer.

Top module: `et_out_select`

## Requirements
- R1: After reset, with no host writes, et_out is 8. The control register selects the lookup on live clocks and the fixed register elsewhere, in record mode. The noise register holds 0x01.
- R2: When the lookup is the selected source, et_out in the clock after a sample is presented equals the memory word at that sample address (latency one clock). Host writes use cfg_target 0 with cfg_addr as the memory address.
- R3: Source codes are 0 lookup, 1 fixed, 2 buffer and 3 noise. Control bits [3:2] give the source for clocks with live_xing high, and bits [1:0] give the source for the others. The clock with live_xing high is the one whose choice appears on et_out one clock later. Control is written with cfg_target 2.
- R4: The fixed source outputs the value last written with cfg_target 1 (reset value 8).
- R5: With both control codes set to fixed, et_out equals the fixed value on every clock of a turn, whatever the sample and live_xing inputs are.
- R6: The buffer address is 0 on a clock with turn_start high. Otherwise it advances by one per clock and wraps from 158 to 0.
- R7: With control bit 4 clear (record), the word transmitted for a clock is written to the buffer location of that clock. A later playback turn returns it at the same position.
- R8: With control bit 4 set (playback), the buffer is not written from the output. When the buffer is selected, et_out returns location k one clock after the clock at address k.
- R9: The noise source is an 8-bit Fibonacci shift register that shifts left once per clock, taking in bit7^bit5^bit4^bit3 (x^8+x^6+x^5+x^4+1). A write with cfg_target 3 loads cfg_wdata, and a zero seed loads 0x01 instead. It is never zero.
- R10: Host writes with cfg_target 4 load buffer location cfg_addr (addresses 159 and up are dropped) and take priority over recording.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Crossing clock |
| rst | input | 1 | Synchronous active-high reset |
| sample_in | input | 10 | Filtered sample, lookup address |
| live_xing | input | 1 | Marks a clock holding a live beam crossing |
| turn_start | input | 1 | Marks the first clock of a turn |
| cfg_we | input | 1 | Host write strobe |
| cfg_target | input | 3 | Write target: 0 lookup, 1 fixed, 2 control, 3 seed, 4 buffer |
| cfg_addr | input | 10 | Address for lookup or buffer writes |
| cfg_wdata | input | 8 | Write data |
| et_out | output | 8 | Transmitted Et word |

## Verification
A wrong buffer pointer shows up as words that are off by one or more positions in the playback of a recorded turn. It also shows up at the first clock after a turn marker, which must return location 0. A wrong pointer is therefore seen within one turn of 159 clocks. A wrong selection register or live-crossing mapping puts the fixed value where the lookup word belongs, or the reverse, on the very next clock. The noise register is compared word by word against an independent model right after seeding, so a wrong tap or zero-seed rule differs within a few clocks.

// File: rtl/et_sel_pkg.sv
package et_sel_pkg;

    typedef enum logic [1:0] {
        SRC_LUT   = 2'd0,
        SRC_FIXED = 2'd1,
        SRC_BUF   = 2'd2,
        SRC_NOISE = 2'd3
    } src_e;

    typedef enum logic [2:0] {
        TGT_LUT   = 3'd0,
        TGT_FIXED = 3'd1,
        TGT_CTRL  = 3'd2,
        TGT_SEED  = 3'd3,
        TGT_BUF   = 3'd4
    } tgt_e;

    typedef struct packed {
        logic playback;
        src_e live_src;
        src_e idle_src;
    } sel_ctrl_t;

    localparam int CTRL_W = $bits(sel_ctrl_t);

    localparam sel_ctrl_t CTRL_RST = '{playback: 1'b0, live_src: SRC_LUT, idle_src: SRC_FIXED};

    // taps at bits 7,5,4,3 for x^8+x^6+x^5+x^4+1
    localparam logic [7:0] NOISE_TAPS = 8'hB8;

    function automatic logic [7:0] noise_step(input logic [7:0] cur);
        return {cur[6:0], ^(cur & NOISE_TAPS)};
    endfunction

endpackage

// File: rtl/et_lut.sv
module et_lut #(
    parameter int AW = 10,
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [DW-1:0] wdata,
    input  logic [AW-1:0] raddr,
    output logic [DW-1:0] rdata
);
    localparam int DEPTH = 1 << AW;

    logic [DW-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we) begin
            mem[waddr] <= wdata;
        end
        rdata <= mem[raddr];
    end
endmodule

// File: rtl/et_noise_gen.sv
module et_noise_gen
    import et_sel_pkg::*;
#(
    parameter logic [7:0] SEED_RST = 8'h01
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       seed_we,
    input  logic [7:0] seed,
    output logic [7:0] q
);
    always_ff @(posedge clk) begin
        if (rst) begin
            q <= (SEED_RST == 8'h00) ? 8'h01 : SEED_RST;
        end else if (seed_we) begin
            q <= (seed == 8'h00) ? 8'h01 : seed;
        end else begin
            q <= noise_step(q);
        end
    end
endmodule

// File: rtl/et_turn_buf.sv
module et_turn_buf #(
    parameter int DEPTH = 159,
    parameter int DW    = 8,
    localparam int AW   = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          turn_start,
    input  logic          playback,
    input  logic [DW-1:0] rec_data,
    input  logic          host_we,
    input  logic [AW-1:0] host_addr,
    input  logic [DW-1:0] host_wdata,
    output logic [DW-1:0] rd_data,
    output logic [AW-1:0] cur_addr
);
    localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

    logic [DW-1:0] mem [DEPTH];
    logic [AW-1:0] ptr_q;
    logic [AW-1:0] wr_addr_q;
    logic          wr_ok_q;

    assign cur_addr = turn_start ? '0 : ptr_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            ptr_q     <= '0;
            wr_addr_q <= '0;
            wr_ok_q   <= 1'b0;
        end else begin
            ptr_q     <= (cur_addr == LAST) ? '0 : cur_addr + AW'(1);
            wr_addr_q <= cur_addr;
            wr_ok_q   <= 1'b1;
        end
    end

    // the word in rec_data is the one transmitted for address wr_addr_q
    always_ff @(posedge clk) begin
        rd_data <= mem[cur_addr];
        if (host_we) begin
            mem[host_addr] <= host_wdata;
        end else if (!rst && wr_ok_q && !playback) begin
            mem[wr_addr_q] <= rec_data;
        end
    end
endmodule

// File: rtl/et_out_select.sv
module et_out_select
    import et_sel_pkg::*;
#(
    parameter int SMP_W     = 10,
    parameter int ET_W      = 8,
    parameter int TURN_LEN  = 159,
    parameter int FIXED_RST = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [SMP_W-1:0] sample_in,
    input  logic             live_xing,
    input  logic             turn_start,
    input  logic             cfg_we,
    input  logic [2:0]       cfg_target,
    input  logic [SMP_W-1:0] cfg_addr,
    input  logic [ET_W-1:0]  cfg_wdata,
    output logic [ET_W-1:0]  et_out
);
    localparam int BUF_AW = $clog2(TURN_LEN);

    tgt_e          tgt;
    sel_ctrl_t     ctrl_q;
    logic [ET_W-1:0] fixed_q;
    src_e          sel_d;
    src_e          sel_q;
    logic [ET_W-1:0] lut_q;
    logic [ET_W-1:0] buf_q;
    logic [7:0]    lfsr_q;
    logic [BUF_AW-1:0] buf_addr;
    logic          lut_we;
    logic          seed_we;
    logic          buf_we;

    assign tgt     = tgt_e'(cfg_target);
    assign lut_we  = cfg_we && (tgt == TGT_LUT);
    assign seed_we = cfg_we && (tgt == TGT_SEED);
    assign buf_we  = cfg_we && (tgt == TGT_BUF) && (cfg_addr < SMP_W'(TURN_LEN));

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q  <= CTRL_RST;
            fixed_q <= ET_W'(FIXED_RST);
        end else if (cfg_we) begin
            if (tgt == TGT_CTRL) begin
                ctrl_q <= sel_ctrl_t'(cfg_wdata[CTRL_W-1:0]);
            end
            if (tgt == TGT_FIXED) begin
                fixed_q <= cfg_wdata;
            end
        end
    end

    assign sel_d = live_xing ? ctrl_q.live_src : ctrl_q.idle_src;

    always_ff @(posedge clk) begin
        if (rst) begin
            sel_q <= SRC_FIXED;
        end else begin
            sel_q <= sel_d;
        end
    end

    et_lut #(.AW(SMP_W), .DW(ET_W)) u_lut (
        .clk   (clk),
        .we    (lut_we),
        .waddr (cfg_addr),
        .wdata (cfg_wdata),
        .raddr (sample_in),
        .rdata (lut_q)
    );

    et_noise_gen #(.SEED_RST(8'h01)) u_noise (
        .clk     (clk),
        .rst     (rst),
        .seed_we (seed_we),
        .seed    (cfg_wdata[7:0]),
        .q       (lfsr_q)
    );

    et_turn_buf #(.DEPTH(TURN_LEN), .DW(ET_W)) u_buf (
        .clk        (clk),
        .rst        (rst),
        .turn_start (turn_start),
        .playback   (ctrl_q.playback),
        .rec_data   (et_out),
        .host_we    (buf_we),
        .host_addr  (cfg_addr[BUF_AW-1:0]),
        .host_wdata (cfg_wdata),
        .rd_data    (buf_q),
        .cur_addr   (buf_addr)
    );

    always_comb begin
        unique case (sel_q)
            SRC_LUT:   et_out = lut_q;
            SRC_FIXED: et_out = fixed_q;
            SRC_BUF:   et_out = buf_q;
            SRC_NOISE: et_out = ET_W'(lfsr_q);
        endcase
    end
endmodule

// File: rtl/et_out_select_chk.sv
module et_out_select_chk #(
    parameter int ET_W      = 8,
    parameter int TURN_LEN  = 159,
    parameter int FIXED_RST = 8,
    localparam int AW       = $clog2(TURN_LEN)
) (
    input logic            clk,
    input logic            rst,
    input logic            live_xing,
    input logic            turn_start,
    input logic [4:0]      ctrl_bits,
    input logic [ET_W-1:0] fixed_q,
    input logic [ET_W-1:0] lut_q,
    input logic [7:0]      lfsr_q,
    input logic [AW-1:0]   buf_addr,
    input logic [ET_W-1:0] et_out
);
    a_r1_reset_out: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> et_out == ET_W'(FIXED_RST));

    a_r3_live_lut: assert property (@(posedge clk) disable iff (rst)
        (live_xing && ctrl_bits[3:2] == 2'd0) |=> et_out == lut_q);

    a_r3_idle_noise: assert property (@(posedge clk) disable iff (rst)
        (!live_xing && ctrl_bits[1:0] == 2'd3) |=> et_out == ET_W'(lfsr_q));

    a_r5_mask: assert property (@(posedge clk) disable iff (rst)
        (ctrl_bits[3:2] == 2'd1 && ctrl_bits[1:0] == 2'd1) |=> et_out == fixed_q);

    a_r6_addr_range: assert property (@(posedge clk) disable iff (rst)
        buf_addr < AW'(TURN_LEN));

    a_r6_addr_step: assert property (@(posedge clk) disable iff (rst)
        ($past(!rst) && !turn_start) |->
            buf_addr == (($past(buf_addr) == AW'(TURN_LEN - 1)) ? AW'(0) : $past(buf_addr) + AW'(1)));

    a_r9_nonzero: assert property (@(posedge clk) disable iff (rst)
        lfsr_q != 8'h00);
endmodule

bind et_out_select et_out_select_chk #(
    .ET_W(ET_W), .TURN_LEN(TURN_LEN), .FIXED_RST(FIXED_RST)
) u_chk (
    .clk        (clk),
    .rst        (rst),
    .live_xing  (live_xing),
    .turn_start (turn_start),
    .ctrl_bits  (ctrl_q),
    .fixed_q    (fixed_q),
    .lut_q      (lut_q),
    .lfsr_q     (lfsr_q),
    .buf_addr   (buf_addr),
    .et_out     (et_out)
);

// File: tb/test_et_out_select.sv
module test_et_out_select;
    logic       clk = 1'b0;
    logic       rst;
    logic [9:0] sample_in;
    logic       live_xing;
    logic       turn_start;
    logic       cfg_we;
    logic [2:0] cfg_target;
    logic [9:0] cfg_addr;
    logic [7:0] cfg_wdata;
    logic [7:0] et_out;

    int n_chk  = 0;
    int n_fail = 0;
    logic [7:0] rec [159];

    always #4 clk = ~clk;

    et_out_select i_et_out_select (
        .clk(clk), .rst(rst), .sample_in(sample_in), .live_xing(live_xing),
        .turn_start(turn_start), .cfg_we(cfg_we), .cfg_target(cfg_target),
        .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata), .et_out(et_out)
    );

    // {live, sample, expected} under physics control, line (x-18)/4
    localparam logic [18:0] VECS [12] = '{
        {1'b1, 10'd50,   8'd8},
        {1'b1, 10'd100,  8'd20},
        {1'b1, 10'd1023, 8'd251},
        {1'b1, 10'd10,   8'd0},
        {1'b0, 10'd300,  8'd8},
        {1'b1, 10'd18,   8'd0},
        {1'b1, 10'd21,   8'd0},
        {1'b1, 10'd22,   8'd1},
        {1'b1, 10'd530,  8'd128},
        {1'b0, 10'd50,   8'd8},
        {1'b1, 10'd0,    8'd0},
        {1'b1, 10'd514,  8'd124}
    };

    function automatic logic [7:0] line_val(input int x);
        return (x < 18) ? 8'd0 : 8'((x - 18) / 4);
    endfunction

    function automatic logic [7:0] lfsr_model(input logic [7:0] v);
        return {v[6:0], v[7] ^ v[5] ^ v[4] ^ v[3]};
    endfunction

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: et_out=%0d expected %0d", req, act, exp);
        end
    endtask

    task automatic cyc(input logic lv, input logic ts, input logic [9:0] smp);
        live_xing  = lv;
        turn_start = ts;
        sample_in  = smp;
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic wr(input logic [2:0] tgt, input logic [9:0] addr, input logic [7:0] data);
        cfg_we     = 1'b1;
        cfg_target = tgt;
        cfg_addr   = addr;
        cfg_wdata  = data;
        cyc(1'b0, 1'b0, 10'd0);
        cfg_we = 1'b0;
    endtask

    task automatic summary;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: et_out=%0d expected completion", et_out);
        summary();
        $finish;
    end

    initial begin
        logic [7:0] m;
        rst = 1'b1; cfg_we = 1'b0; cfg_target = 3'd0; cfg_addr = '0; cfg_wdata = '0;
        live_xing = 1'b0; turn_start = 1'b0; sample_in = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        // R1: reset value on idle clocks
        cyc(1'b0, 1'b0, 10'd77);
        chk("R1", et_out, 8'd8);
        cyc(1'b0, 1'b0, 10'd500);
        chk("R1", et_out, 8'd8);

        // R2: load lookup line
        for (int x = 0; x < 1024; x++) wr(3'd0, 10'(x), line_val(x));

        // R2/R3: vector table in physics mode
        foreach (VECS[i]) begin
            cyc(VECS[i][18], 1'b0, VECS[i][17:8]);
            chk("R2", et_out, VECS[i][7:0]);
        end

        // R3: reversed codes, live->fixed, idle->lookup
        wr(3'd2, 10'd0, 8'h04);
        cyc(1'b1, 1'b0, 10'd530);
        chk("R3", et_out, 8'd8);
        cyc(1'b0, 1'b0, 10'd530);
        chk("R3", et_out, 8'd128);

        // R4/R5: masked channel with new fixed value
        wr(3'd1, 10'd0, 8'h5A);
        wr(3'd2, 10'd0, 8'h05);
        for (int k = 0; k < 159; k++) begin
            cyc(1'(k % 2), k == 0, 10'((k * 53) % 1024));
            chk("R5", et_out, 8'h5A);
        end

        // R9: noise with zero seed then nonzero seed
        wr(3'd2, 10'd0, 8'h0F);
        wr(3'd3, 10'd0, 8'h00);
        m = 8'h01;
        chk("R9", et_out, m);
        for (int k = 0; k < 20; k++) begin
            cyc(1'(k % 3 == 0), 1'b0, 10'd0);
            m = lfsr_model(m);
            chk("R9", et_out, m);
        end
        wr(3'd3, 10'd0, 8'hA5);
        m = 8'hA5;
        chk("R9", et_out, m);
        for (int k = 0; k < 12; k++) begin
            cyc(1'b0, 1'b0, 10'd0);
            m = lfsr_model(m);
            chk("R9", et_out, m);
        end

        // R7: record one physics turn
        wr(3'd1, 10'd0, 8'd8);
        wr(3'd2, 10'd0, 8'h01);
        for (int k = 0; k < 159; k++) begin
            logic lv;
            logic [9:0] s;
            lv = (k % 3 == 0);
            s  = 10'((k * 37) % 1024);
            rec[k] = lv ? line_val(int'(s)) : 8'd8;
            cyc(lv, k == 0, s);
            chk("R3", et_out, rec[k]);
        end
        // playback, both classes from buffer
        wr(3'd2, 10'd0, 8'h1A);
        cyc(1'b0, 1'b0, 10'd0);
        for (int k = 0; k < 159; k++) begin
            cyc(1'(k % 2), k == 0, 10'd3);
            chk("R7", et_out, rec[k]);
        end
        // R6: wrap without marker
        cyc(1'b0, 1'b0, 10'd0);
        chk("R6", et_out, rec[0]);
        for (int k = 1; k <= 40; k++) cyc(1'b0, 1'b0, 10'd0);
        chk("R6", et_out, rec[40]);
        cyc(1'b0, 1'b1, 10'd0);
        chk("R6", et_out, rec[0]);
        cyc(1'b0, 1'b0, 10'd0);
        chk("R6", et_out, rec[1]);

        // R8/R10: host preload then replay; out-of-range write dropped
        for (int k = 0; k < 159; k++) wr(3'd4, 10'(k), 8'((k * 11 + 5) % 256));
        wr(3'd4, 10'd159, 8'hEE);
        for (int k = 0; k < 159; k++) begin
            cyc(1'(k % 5 == 0), k == 0, 10'd0);
            chk("R8", et_out, 8'((k * 11 + 5) % 256));
        end
        cyc(1'b0, 1'b0, 10'd0);
        chk("R10", et_out, 8'd5);

        summary();
        $finish;
    end
endmodule